// File: doc/BRIEF.md
# Pipeline Exception Cause and EPC Capture

This unit sits beside a five-stage pipeline and turns fault strobes from three stages into one recorded exception. The decode stage reports an undecodable instruction. The execute stage reports a division by zero and an instruction fetch address outside instruction memory. The memory stage reports a stack overflow, a stack underflow and a data address outside data memory. Each stage also hands over the PC of the instruction it currently holds.

In any cycle with at least one fault strobe, the unit accepts one exception. It picks the oldest faulting instruction, which is the one furthest down the pipe. On the next clock edge it loads that instruction's own PC into a 32-bit exception PC register and a 4-bit reason code into a cause register. In the cycle after acceptance it raises a taken pulse. Flushing the pipe and redirecting fetch to a handler belong to the surrounding logic.

Top module: `excCapture`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears epc, cause and excTaken to 0, even when fault strobes are active in that cycle.
- R2: Cause codes are fixed: 0 means none (reset value only), 1 means stack overflow, 2 means stack underflow, 3 means invalid instruction, 4 means divide by zero, 5 means instruction address out of range and 6 means data address out of range. The code of the accepted fault appears on cause one clock edge after its strobe is sampled high.
- R3: epc receives the PC input of the stage whose fault is accepted, sampled in the same cycle as the strobe. This is the faulting instruction's own address.
- R4: Any memory-stage fault wins over every execute-stage and decode-stage fault in the same cycle.
- R5: Any execute-stage fault wins over a decode-stage fault in the same cycle.
- R6: Within the memory stage, stack overflow wins over stack underflow, and stack underflow wins over a data address out of range.
- R7: Within the execute stage, divide by zero wins over an instruction address out of range.
- R8: In a cycle with no fault strobe, epc and cause keep their values.
- R9: excTaken is high for exactly those cycles that follow a clock edge at which at least one fault strobe was sampled high outside reset. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decInvalid | input | 1 | Decode stage holds an undecodable instruction |
| decPc | input | PC_W | PC of the decode-stage instruction |
| exDivZero | input | 1 | Execute stage divides by zero |
| exImemOob | input | 1 | Execute stage computed an instruction address out of range |
| exPc | input | PC_W | PC of the execute-stage instruction |
| memStackOver | input | 1 | Memory stage push past the stack limit |
| memStackUnder | input | 1 | Memory stage pop below the stack base |
| memDmemOob | input | 1 | Memory stage data address out of range |
| memPc | input | PC_W | PC of the memory-stage instruction |
| epc | output | PC_W | Address of the last accepted faulting instruction |
| cause | output | 4 | Reason code of the last accepted fault |
| excTaken | output | 1 | High for one cycle after each accepted fault cycle |

## Verification
The bench drives every fault alone and then in colliding sets, with different PCs on each stage, so the choice of winner shows up in epc as well as in cause. One design error is ranking stages by age the wrong way round, which would report the decode fault of a younger instruction. Another is swapping the order inside a stage, which would report underflow or a bad data address when a stack overflow is also present. A third is taking the PC from the wrong stage, which would give a correct code with another instruction's address. Idle cycles after a capture test whether the registers hold their values or slide back to code 0 or to a stale PC. A reset applied while strobes are active tests whether reset is given precedence over capture.

// File: rtl/excPkg.sv
package excPkg;
  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE       = 4'd0,
    CAUSE_STK_OVER   = 4'd1,
    CAUSE_STK_UNDER  = 4'd2,
    CAUSE_BAD_INSTR  = 4'd3,
    CAUSE_DIV_ZERO   = 4'd4,
    CAUSE_IMEM_RANGE = 4'd5,
    CAUSE_DMEM_RANGE = 4'd6
  } causeCode_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEC  = 2'd1,
    SRC_EX   = 2'd2,
    SRC_MEM  = 2'd3
  } pcSrc_t;

  typedef struct packed {
    logic       take;
    pcSrc_t     srcSel;
    causeCode_t code;
  } excCtl_t;
endpackage

// File: rtl/excControl.sv
module excControl
  import excPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    decInvalid,
  input  logic    exDivZero,
  input  logic    exImemOob,
  input  logic    memStackOver,
  input  logic    memStackUnder,
  input  logic    memDmemOob,
  output excCtl_t ctl
);
  logic memAny, exAny, decAny;

  assign memAny = memStackOver | memStackUnder | memDmemOob;
  assign exAny  = exDivZero | exImemOob;
  assign decAny = decInvalid;

  // Oldest instruction first: memory, then execute, then decode.
  always_comb begin
    ctl.take   = memAny | exAny | decAny;
    ctl.srcSel = SRC_NONE;
    ctl.code   = CAUSE_NONE;
    if (memAny) begin
      ctl.srcSel = SRC_MEM;
      if (memStackOver)       ctl.code = CAUSE_STK_OVER;
      else if (memStackUnder) ctl.code = CAUSE_STK_UNDER;
      else                    ctl.code = CAUSE_DMEM_RANGE;
    end else if (exAny) begin
      ctl.srcSel = SRC_EX;
      if (exDivZero) ctl.code = CAUSE_DIV_ZERO;
      else           ctl.code = CAUSE_IMEM_RANGE;
    end else if (decAny) begin
      ctl.srcSel = SRC_DEC;
      ctl.code   = CAUSE_BAD_INSTR;
    end
  end

  // R5: a decode fault is never chosen while an execute fault is present
  a_r5_ex_over_dec: assert property (@(posedge clk) disable iff (rst)
    exAny |-> (ctl.srcSel != SRC_DEC));

  // R4: a memory fault always selects the memory-stage PC
  a_r4_mem_first: assert property (@(posedge clk) disable iff (rst)
    memAny |-> (ctl.srcSel == SRC_MEM));
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  excCtl_t            ctl,
  input  logic [PC_W-1:0]    decPc,
  input  logic [PC_W-1:0]    exPc,
  input  logic [PC_W-1:0]    memPc,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               excTaken
);
  logic [PC_W-1:0] pcPick;

  always_comb begin
    case (ctl.srcSel)
      SRC_MEM: pcPick = memPc;
      SRC_EX:  pcPick = exPc;
      SRC_DEC: pcPick = decPc;
      default: pcPick = epc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      epc      <= '0;
      cause    <= '0;
      excTaken <= 1'b0;
    end else begin
      excTaken <= ctl.take;
      if (ctl.take) begin
        epc   <= pcPick;
        cause <= ctl.code;
      end
    end
  end

  // R8: registers hold across a cycle with no accepted fault
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.take |=> ($stable(epc) && $stable(cause)));

  // R2: cause stays within the defined code range
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    cause <= 4'd6);
endmodule

// File: rtl/excCapture.sv
module excCapture
  import excPkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               decInvalid,
  input  logic [PC_W-1:0]    decPc,
  input  logic               exDivZero,
  input  logic               exImemOob,
  input  logic [PC_W-1:0]    exPc,
  input  logic               memStackOver,
  input  logic               memStackUnder,
  input  logic               memDmemOob,
  input  logic [PC_W-1:0]    memPc,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause,
  output logic               excTaken
);
  excCtl_t ctl;

  excControl uCtl (
    .clk(clk), .rst(rst),
    .decInvalid(decInvalid), .exDivZero(exDivZero), .exImemOob(exImemOob),
    .memStackOver(memStackOver), .memStackUnder(memStackUnder),
    .memDmemOob(memDmemOob), .ctl(ctl)
  );

  excDatapath #(.PC_W(PC_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .decPc(decPc), .exPc(exPc), .memPc(memPc),
    .epc(epc), .cause(cause), .excTaken(excTaken)
  );

  logic anyFault;
  assign anyFault = decInvalid | exDivZero | exImemOob |
                    memStackOver | memStackUnder | memDmemOob;

  // R9: taken pulse follows exactly the cycles with a fault
  a_r9_taken_follows: assert property (@(posedge clk) disable iff (rst)
    anyFault |=> excTaken);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !anyFault |=> !excTaken);

  // R6 / R3: stack overflow records code 1 with the memory-stage PC
  a_r6_overflow_wins: assert property (@(posedge clk) disable iff (rst)
    memStackOver |=> (cause == 4'd1 && epc == $past(memPc)));

  // R3 / R5: lone decode fault records code 3 with the decode-stage PC
  a_r3_dec_pc: assert property (@(posedge clk) disable iff (rst)
    (decInvalid && !exDivZero && !exImemOob && !memStackOver &&
     !memStackUnder && !memDmemOob)
    |=> (cause == 4'd3 && epc == $past(decPc)));

  // R7: divide by zero beats instruction range when no memory fault
  a_r7_div_first: assert property (@(posedge clk) disable iff (rst)
    (exDivZero && !memStackOver && !memStackUnder && !memDmemOob)
    |=> (cause == 4'd4 && epc == $past(exPc)));
endmodule

// File: tb/tb_excCapture.sv
module tb_excCapture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        decInvalid = 0, exDivZero = 0, exImemOob = 0;
  logic        memStackOver = 0, memStackUnder = 0, memDmemOob = 0;
  logic [31:0] decPc = 0, exPc = 0, memPc = 0;
  logic [31:0] epc;
  logic [3:0]  cause;
  logic        excTaken;

  always #4 clk = ~clk;

  excCapture #(.PC_W(32)) dut (
    .clk(clk), .rst(rst),
    .decInvalid(decInvalid), .decPc(decPc),
    .exDivZero(exDivZero), .exImemOob(exImemOob), .exPc(exPc),
    .memStackOver(memStackOver), .memStackUnder(memStackUnder),
    .memDmemOob(memDmemOob), .memPc(memPc),
    .epc(epc), .cause(cause), .excTaken(excTaken)
  );

  typedef struct {
    logic        taken;
    logic [31:0] epcV;
    logic [3:0]  causeV;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  int          nChecks = 0;
  int          nFails  = 0;
  logic [31:0] mEpc = 0;
  logic [3:0]  mCause = 0;
  bit          finished = 0;

  // fault bits: {memStackOver, memStackUnder, memDmemOob, exDivZero, exImemOob, decInvalid}
  task automatic step(input logic [5:0] f, input logic [31:0] dp, ep, mp,
                      input logic doRst, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = doRst;
    {memStackOver, memStackUnder, memDmemOob, exDivZero, exImemOob, decInvalid} = f;
    decPc = dp; exPc = ep; memPc = mp;
    if (doRst) begin
      mEpc = 0; mCause = 0; it.taken = 0;
    end else begin
      it.taken = |f;
      if (f[5])      begin mCause = 1; mEpc = mp; end
      else if (f[4]) begin mCause = 2; mEpc = mp; end
      else if (f[3]) begin mCause = 6; mEpc = mp; end
      else if (f[2]) begin mCause = 4; mEpc = ep; end
      else if (f[1]) begin mCause = 5; mEpc = ep; end
      else if (f[0]) begin mCause = 3; mEpc = dp; end
    end
    it.epcV = mEpc; it.causeV = mCause; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        expItem_t e;
        e = sb.pop_front();
        nChecks++;
        if (excTaken !== e.taken) begin
          nFails++;
          $display("FAIL %s excTaken actual=%0b expected=%0b", e.tag, excTaken, e.taken);
        end
        nChecks++;
        if (cause !== e.causeV) begin
          nFails++;
          $display("FAIL %s cause actual=%0d expected=%0d", e.tag, cause, e.causeV);
        end
        nChecks++;
        if (epc !== e.epcV) begin
          nFails++;
          $display("FAIL %s epc actual=%h expected=%h", e.tag, epc, e.epcV);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    step(6'b111111, 32'h11, 32'h22, 32'h33, 1, "R1 reset beats faults");
    step(6'b000000, 32'h11, 32'h22, 32'h33, 0, "R1 R8 idle after reset");
    step(6'b100000, 32'h10, 32'h20, 32'h100, 0, "R2 R3 overflow");
    step(6'b000000, 32'h1,  32'h2,  32'h3,   0, "R8 R9 hold after overflow");
    step(6'b010000, 32'h10, 32'h20, 32'h104, 0, "R2 underflow");
    step(6'b001000, 32'h10, 32'h20, 32'h108, 0, "R2 data range");
    step(6'b000100, 32'h10, 32'h2C, 32'h10C, 0, "R2 R3 divide by zero");
    step(6'b000010, 32'h10, 32'h30, 32'h110, 0, "R2 instr range");
    step(6'b000001, 32'h44, 32'h34, 32'h114, 0, "R2 R3 invalid instr");
    step(6'b000000, 32'h5,  32'h6,  32'h7,   0, "R8 hold after decode");
    step(6'b111111, 32'hA1, 32'hA2, 32'hA3,  0, "R4 all faults");
    step(6'b000101, 32'hB1, 32'hB2, 32'hB3,  0, "R5 ex over decode");
    step(6'b000011, 32'hC1, 32'hC2, 32'hC3,  0, "R5 instr range over decode");
    step(6'b011100, 32'hD1, 32'hD2, 32'hD3,  0, "R6 underflow over data range");
    step(6'b101000, 32'hE1, 32'hE2, 32'hE3,  0, "R6 overflow over data range");
    step(6'b110000, 32'hE5, 32'hE6, 32'hE7,  0, "R6 overflow over underflow");
    step(6'b000110, 32'hF1, 32'hF2, 32'hF3,  0, "R7 divide over instr range");
    step(6'b001011, 32'h91, 32'h92, 32'h93,  0, "R4 data range over ex");
    step(6'b000001, 32'h7001, 32'h7002, 32'h7003, 0, "R9 back to back 1");
    step(6'b000100, 32'h7011, 32'h7012, 32'h7013, 0, "R9 back to back 2");
    step(6'b000000, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, "R8 idle 1");
    step(6'b000000, 32'h1234, 32'h5678, 32'h9ABC, 0, "R8 idle 2");
    step(6'b010000, 32'h0, 32'h0, 32'hDEAD_BEEF, 0, "R3 wide pc");
    step(6'b000000, 32'h0, 32'h0, 32'h0, 1, "R1 mid-run reset");
    step(6'b000000, 32'h0, 32'h0, 32'h0, 0, "R1 after mid reset");
    repeat (3) @(posedge clk);
    #3;
    if (sb.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R9 scoreboard drain actual=%0d expected=0", sb.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule